// File: doc/BRIEF.md
# Two-Backplane Multiplexed Seven-Segment LCD Driver

This block drives a three-and-a-half digit seven-segment liquid crystal panel that has two backplane electrodes. Each segment line is shared by two segments, one facing each backplane, so fifteen lines plus two backplane pins serve thirty segments. A refresh frame has four phases of equal length, called Ta, Tb, Tc and Td here. In each phase one backplane is actively driven high or low and the other is released to high impedance. An external resistor divider pulls a released backplane to half the supply. The segment lines carry inverted data in the first half of the frame and true data in the second half, so every segment sees a drive with zero average voltage.

The caller supplies three full digit codes, a two-bit code for the leading half digit, one decimal-point enable per full digit and a display enable. Digit data is captured only when a frame starts, so a frame never mixes old and new values. When the display is off, every pin is driven low.

Top module: `lcd2x_driver`

## Requirements
- R1: Phases run in the order Ta, Tb, Tc, Td and then repeat. Each phase lasts exactly CLK_DIV*PHASE_TICKS clock cycles. The defaults of 500 and 2500 give a 5 ms phase at 250 MHz.
- R2: Backplane drive per phase. In Ta, bp1 is driven high and bp2 is released. In Tb, bp2 is driven high and bp1 is released. In Tc, bp1 is driven low and bp2 is released. In Td, bp2 is driven low and bp1 is released. A released pin has oe=0 and val=0, and exactly one backplane is driven while running.
- R3: Each segment line k has a bp1 segment on1[k] and a bp2 segment on2[k]. The line is driven to ~on1[k] in Ta, ~on2[k] in Tb, on1[k] in Tc and on2[k] in Td. A lit segment is therefore always driven opposite to its active backplane, and Tc/Td are the complements of Ta/Tb.
- R4: Line map for full digit i (lines 4i..4i+3), written as (bp1, bp2): (a, f), (b, g), (c, e), (decimal point, d). The top digit uses lines 12..14 with (a, g), (b, e), (c, d).
- R5: Full digit codes 0 to 9 light the usual seven-segment patterns: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg. Codes 10 to 15 are blank.
- R6: Decimal-point enable bit i lights the point of full digit i, independent of the digit code.
- R7: Top digit code 0 is blank, 1 lights bc, 2 lights abdeg and 3 lights abcdg.
- R8: If disp_en is sampled low while running, then from the next cycle every segment line is 0 and both backplanes are driven (oe=1) low.
- R9: When disp_en is sampled high while stopped, the next cycle starts a fresh frame in Ta, using the inputs sampled on that edge.
- R10: Digit, top and decimal-point inputs are captured only at the start of a frame. A change inside a frame has no effect until the next Ta.
- R11: During and after reset with disp_en low, the outputs are in the disabled state of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_en | input | 1 | Display enable |
| dig_code | input | 4*NUM_FULL | Full digit codes, digit 0 in the low nibble |
| top_code | input | 2 | Leading half digit code |
| dp_en | input | NUM_FULL | Decimal-point enable per full digit |
| seg_line | output | 4*NUM_FULL+3 | Segment line levels |
| bp1_val | output | 1 | Backplane 1 drive level |
| bp1_oe | output | 1 | Backplane 1 output enable (0 = released) |
| bp2_val | output | 1 | Backplane 2 drive level |
| bp2_oe | output | 1 | Backplane 2 output enable (0 = released) |

## Verification
The hardest behaviour to reach from the ports is the frame-boundary capture. It can only be seen by changing the digit inputs part-way through a frame and confirming that every later phase of that frame still shows the old value. The stimulus therefore swaps codes during Ta and again one cycle into a new frame. It also turns the display off in the middle of Tb and back on a few cycles later, which checks that the phase timer restarts cleanly from Ta. Small timer parameters keep a frame to 24 cycles, so the first and last cycle of every phase can be checked.

// File: rtl/lcd2x_pkg.sv
package lcd2x_pkg;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2,
        PH_D = 2'd3
    } phase_e;

    // drive state of one backplane pin
    typedef struct packed {
        logic val;
        logic oe;
    } bp_drive_t;

    localparam int LINES_PER_FULL = 4;
    localparam int TOP_LINES      = 3;

    // bit order {g,f,e,d,c,b,a}
    function automatic logic [6:0] seg7_full(input logic [3:0] code);
        logic [6:0] s;
        case (code)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

    function automatic logic [6:0] seg7_top(input logic [1:0] code);
        logic [6:0] s;
        case (code)
            2'd1:    s = 7'h06;
            2'd2:    s = 7'h5B;
            2'd3:    s = 7'h4F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lcd2x_tick_timer.sv
module lcd2x_tick_timer #(
    parameter int CLK_DIV     = 500,
    parameter int PHASE_TICKS = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic phase_end
);
    localparam int PRE_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int PH_W  = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LOAD = PRE_W'(CLK_DIV - 1);
    localparam logic [PH_W-1:0]  PH_LOAD  = PH_W'(PHASE_TICKS - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [PH_W-1:0]  ph_cnt;
    logic             tick;

    assign tick      = run && (pre_cnt == '0);
    assign phase_end = tick && (ph_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= PRE_LOAD;
            ph_cnt  <= PH_LOAD;
        end else if (tick) begin
            pre_cnt <= PRE_LOAD;
            ph_cnt  <= (ph_cnt == '0) ? PH_LOAD : ph_cnt - 1'b1;
        end else begin
            pre_cnt <= pre_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/lcd2x_phase_seq.sv
module lcd2x_phase_seq
    import lcd2x_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   disp_en,
    input  logic   phase_end,
    output logic   run,
    output phase_e phase,
    output logic   frame_load
);
    logic start_frame;
    logic wrap_frame;

    assign start_frame = disp_en && !run;
    assign wrap_frame  = disp_en && run && phase_end && (phase == PH_D);
    assign frame_load  = start_frame || wrap_frame;

    always_ff @(posedge clk) begin
        if (rst || !disp_en) begin
            run   <= 1'b0;
            phase <= PH_A;
        end else if (start_frame) begin
            run   <= 1'b1;
            phase <= PH_A;
        end else if (phase_end) begin
            phase <= phase_e'(phase + 2'd1);
        end
    end
endmodule

// File: rtl/lcd2x_seg_encode.sv
module lcd2x_seg_encode
    import lcd2x_pkg::*;
#(
    parameter int NUM_FULL = 3
) (
    input  logic [4*NUM_FULL-1:0] dig_code,
    input  logic [1:0]            top_code,
    input  logic [NUM_FULL-1:0]   dp_en,
    output logic [LINES_PER_FULL*NUM_FULL+TOP_LINES-1:0] on1,
    output logic [LINES_PER_FULL*NUM_FULL+TOP_LINES-1:0] on2
);
    localparam int TB = LINES_PER_FULL * NUM_FULL;

    for (genvar gi = 0; gi < NUM_FULL; gi++) begin : g_full
        logic [6:0] s;
        assign s = seg7_full(dig_code[4*gi +: 4]);
        assign on1[4*gi+0] = s[0];      // a
        assign on2[4*gi+0] = s[5];      // f
        assign on1[4*gi+1] = s[1];      // b
        assign on2[4*gi+1] = s[6];      // g
        assign on1[4*gi+2] = s[2];      // c
        assign on2[4*gi+2] = s[4];      // e
        assign on1[4*gi+3] = dp_en[gi]; // point
        assign on2[4*gi+3] = s[3];      // d
    end

    logic [6:0] ts;
    assign ts = seg7_top(top_code);
    assign on1[TB+0] = ts[0];
    assign on2[TB+0] = ts[6];
    assign on1[TB+1] = ts[1];
    assign on2[TB+1] = ts[4];
    assign on1[TB+2] = ts[2];
    assign on2[TB+2] = ts[3];
endmodule

// File: rtl/lcd2x_out_drive.sv
module lcd2x_out_drive
    import lcd2x_pkg::*;
#(
    parameter int LINES = 15
) (
    input  logic             run,
    input  phase_e           phase,
    input  logic [LINES-1:0] on1,
    input  logic [LINES-1:0] on2,
    output logic [LINES-1:0] seg,
    output bp_drive_t        bp1,
    output bp_drive_t        bp2
);
    localparam bp_drive_t DRV_HI  = '{val: 1'b1, oe: 1'b1};
    localparam bp_drive_t DRV_LO  = '{val: 1'b0, oe: 1'b1};
    localparam bp_drive_t RELEASE = '{val: 1'b0, oe: 1'b0};

    always_comb begin
        seg = '0;
        bp1 = DRV_LO;
        bp2 = DRV_LO;
        if (run) begin
            case (phase)
                PH_A: begin seg = ~on1; bp1 = DRV_HI;  bp2 = RELEASE; end
                PH_B: begin seg = ~on2; bp1 = RELEASE; bp2 = DRV_HI;  end
                PH_C: begin seg = on1;  bp1 = DRV_LO;  bp2 = RELEASE; end
                default: begin seg = on2; bp1 = RELEASE; bp2 = DRV_LO; end
            endcase
        end
    end
endmodule

// File: rtl/lcd2x_driver.sv
module lcd2x_driver
    import lcd2x_pkg::*;
#(
    parameter int NUM_FULL    = 3,
    parameter int CLK_DIV     = 500,
    parameter int PHASE_TICKS = 2500
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  disp_en,
    input  logic [4*NUM_FULL-1:0] dig_code,
    input  logic [1:0]            top_code,
    input  logic [NUM_FULL-1:0]   dp_en,
    output logic [4*NUM_FULL+2:0] seg_line,
    output logic                  bp1_val,
    output logic                  bp1_oe,
    output logic                  bp2_val,
    output logic                  bp2_oe
);
    localparam int LINES = LINES_PER_FULL * NUM_FULL + TOP_LINES;

    logic             run;
    phase_e           phase;
    logic             phase_end;
    logic             frame_load;
    logic [LINES-1:0] nxt_on1, nxt_on2;
    logic [LINES-1:0] lat_on1, lat_on2;
    bp_drive_t        bp1, bp2;

    lcd2x_tick_timer #(
        .CLK_DIV    (CLK_DIV),
        .PHASE_TICKS(PHASE_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .phase_end(phase_end)
    );

    lcd2x_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .disp_en   (disp_en),
        .phase_end (phase_end),
        .run       (run),
        .phase     (phase),
        .frame_load(frame_load)
    );

    lcd2x_seg_encode #(.NUM_FULL(NUM_FULL)) u_enc (
        .dig_code(dig_code),
        .top_code(top_code),
        .dp_en   (dp_en),
        .on1     (nxt_on1),
        .on2     (nxt_on2)
    );

    // frame capture register: updated only on a frame start
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_on1 <= '0;
            lat_on2 <= '0;
        end else if (frame_load) begin
            lat_on1 <= nxt_on1;
            lat_on2 <= nxt_on2;
        end
    end

    lcd2x_out_drive #(.LINES(LINES)) u_drv (
        .run  (run),
        .phase(phase),
        .on1  (lat_on1),
        .on2  (lat_on2),
        .seg  (seg_line),
        .bp1  (bp1),
        .bp2  (bp2)
    );

    assign bp1_val = bp1.val;
    assign bp1_oe  = bp1.oe;
    assign bp2_val = bp2.val;
    assign bp2_oe  = bp2.oe;
endmodule

// File: rtl/lcd2x_checker.sv
module lcd2x_checker #(
    parameter int LINES = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic [1:0]       phase,
    input logic [LINES-1:0] lat_on1,
    input logic [LINES-1:0] lat_on2,
    input logic [LINES-1:0] seg_line,
    input logic             bp1_val,
    input logic             bp1_oe,
    input logic             bp2_val,
    input logic             bp2_oe
);
    // R2: one backplane driven while running
    a_r2_single_driven: assert property (@(posedge clk) disable iff (rst)
        run |-> ($countones({bp1_oe, bp2_oe}) == 1));

    // R2: a released pin carries val 0
    a_r2_release_quiet: assert property (@(posedge clk) disable iff (rst)
        (!bp1_oe |-> !bp1_val) and (!bp2_oe |-> !bp2_val));

    // R8: off state is all low and driven
    a_r8_off_low: assert property (@(posedge clk) disable iff (rst)
        !run |-> (seg_line == '0) && bp1_oe && bp2_oe && !bp1_val && !bp2_val);

    // R1: phase only ever steps forward by one
    a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (phase != $past(phase))) |-> (phase == $past(phase) + 2'd1));

    // R9: a frame always opens in Ta
    a_r9_start_ta: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (phase == 2'd0));

    // R10: captured segments hold except across the Td to Ta wrap
    a_r10_hold_frame: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !(phase == 2'd0 && $past(phase) == 2'd3))
            |-> ($stable(lat_on1) && $stable(lat_on2)));
endmodule

bind lcd2x_driver lcd2x_checker #(.LINES(LINES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .phase   (phase),
    .lat_on1 (lat_on1),
    .lat_on2 (lat_on2),
    .seg_line(seg_line),
    .bp1_val (bp1_val),
    .bp1_oe  (bp1_oe),
    .bp2_val (bp2_val),
    .bp2_oe  (bp2_oe)
);

// File: tb/lcd2x_driver_bench.sv
`timescale 1ns/1ps
module lcd2x_driver_bench;
    localparam int NF = 3;
    localparam int LN = 4*NF + 3;
    localparam int CD = 2;
    localparam int PT = 3;
    localparam int PH = CD*PT;
    localparam int FR = 4*PH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [11:0]   dig = '0;
    logic [1:0]    top = '0;
    logic [2:0]    dp  = '0;
    logic [LN-1:0] seg;
    logic          b1v, b1o, b2v, b2o;

    always #2 clk = ~clk;

    lcd2x_driver #(.NUM_FULL(NF), .CLK_DIV(CD), .PHASE_TICKS(PT)) u_lcd2x_driver (
        .clk(clk), .rst(rst), .disp_en(en), .dig_code(dig), .top_code(top), .dp_en(dp),
        .seg_line(seg), .bp1_val(b1v), .bp1_oe(b1o), .bp2_val(b2v), .bp2_oe(b2o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [3:0] d0, d1, d2;
        logic [1:0] t;
        logic [2:0] p;
    } frm_t;

    typedef struct {
        int            cyc;
        logic [LN-1:0] seg;
        logic [3:0]    bp;   // {b1v,b1o,b2v,b2o}
        string         tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int bad = 0;
    bit done = 0;

    // R5 reference patterns, bit order {g,f,e,d,c,b,a}
    function automatic logic [6:0] ref_full(input logic [3:0] c);
        case (c)
            4'd0: return 7'b0111111;
            4'd1: return 7'b0000110;
            4'd2: return 7'b1011011;
            4'd3: return 7'b1001111;
            4'd4: return 7'b1100110;
            4'd5: return 7'b1101101;
            4'd6: return 7'b1111101;
            4'd7: return 7'b0000111;
            4'd8: return 7'b1111111;
            4'd9: return 7'b1101111;
            default: return 7'b0;
        endcase
    endfunction

    // R7 reference patterns
    function automatic logic [6:0] ref_top(input logic [1:0] c);
        case (c)
            2'd1: return 7'b0000110;
            2'd2: return 7'b1011011;
            2'd3: return 7'b1001111;
            default: return 7'b0;
        endcase
    endfunction

    // R4 line map
    function automatic void planes(input frm_t f, output logic [LN-1:0] o1, output logic [LN-1:0] o2);
        logic [3:0] dc [3];
        logic [6:0] s;
        dc[0] = f.d0; dc[1] = f.d1; dc[2] = f.d2;
        for (int i = 0; i < NF; i++) begin
            s = ref_full(dc[i]);
            o1[4*i]   = s[0]; o2[4*i]   = s[5];
            o1[4*i+1] = s[1]; o2[4*i+1] = s[6];
            o1[4*i+2] = s[2]; o2[4*i+2] = s[4];
            o1[4*i+3] = f.p[i]; o2[4*i+3] = s[3];
        end
        s = ref_top(f.t);
        o1[12] = s[0]; o2[12] = s[6];
        o1[13] = s[1]; o2[13] = s[4];
        o1[14] = s[2]; o2[14] = s[3];
    endfunction

    task automatic push_phase(input int c, input frm_t f, input int p, input string tag);
        item_t it;
        logic [LN-1:0] o1, o2;
        planes(f, o1, o2);
        it.cyc = c;
        it.tag = tag;
        case (p)
            0: begin it.seg = ~o1; it.bp = 4'b1100; end // R2 R3 Ta
            1: begin it.seg = ~o2; it.bp = 4'b0011; end // Tb
            2: begin it.seg = o1;  it.bp = 4'b0100; end // Tc
            default: begin it.seg = o2; it.bp = 4'b0001; end // Td
        endcase
        q.push_back(it);
    endtask

    task automatic push_off(input int c, input string tag);
        item_t it;
        it.cyc = c; it.seg = '0; it.bp = 4'b0101; it.tag = tag;
        q.push_back(it);
    endtask

    // every phase at its first and last cycle (R1)
    task automatic push_frame(input int b, input frm_t f, input string tag);
        for (int p = 0; p < 4; p++) begin
            push_phase(b + p*PH, f, p, tag);
            push_phase(b + p*PH + PH - 1, f, p, tag);
        end
    endtask

    task automatic apply(input frm_t f);
        dig = {f.d2, f.d1, f.d0};
        top = f.t;
        dp  = f.p;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // monitor: pops expectations and compares at their cycle
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                it = q.pop_front();
                checks++;
                if (it.cyc != cyc || seg !== it.seg || {b1v, b1o, b2v, b2o} !== it.bp) begin
                    bad++;
                    $display("FAIL %s cyc=%0d actual seg=%h bp=%b expected seg=%h bp=%b",
                             it.tag, it.cyc, seg, {b1v, b1o, b2v, b2o}, it.seg, it.bp);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks + 1, bad);
            $finish;
        end
    end

    initial begin
        frm_t fa, fb, fc, fd;
        int c0, base, xoff, base2;
        fa = '{d0: 4'd0, d1: 4'd7, d2: 4'd4, t: 2'd1, p: 3'b010};
        fb = '{d0: 4'd8, d1: 4'd5, d2: 4'd9, t: 2'd3, p: 3'b101};
        fc = '{d0: 4'd2, d1: 4'd6, d2: 4'd15, t: 2'd2, p: 3'b000};
        fd = '{d0: 4'd10, d1: 4'd3, d2: 4'd1, t: 2'd0, p: 3'b100};

        @(negedge clk);
        apply(fa);
        push_off(cyc + 1, "R11 in reset");
        repeat (3) @(negedge clk);
        rst = 1'b0;
        c0 = cyc;
        push_off(c0 + 1, "R11 after reset");
        push_off(c0 + 2, "R11 after reset");

        wait_cyc(c0 + 2);
        en = 1'b1;                         // R9 start
        base = c0 + 3;
        push_frame(base, fa, "R1 R3 R4 R5 R6 R7 R9 frame A");

        wait_cyc(base + 2);
        apply(fb);                          // R10: mid-frame change ignored
        push_frame(base + FR, fb, "R10 R5 R6 R7 frame B");

        wait_cyc(base + FR + 1);
        apply(fc);
        push_phase(base + 2*FR, fc, 0, "R10 R5 R7 frame C");
        push_phase(base + 2*FR + PH - 1, fc, 0, "R10 frame C");
        push_phase(base + 2*FR + PH, fc, 1, "R2 R3 frame C");
        push_phase(base + 2*FR + PH + 1, fc, 1, "R3 frame C");

        xoff = base + 2*FR + PH + 1;
        wait_cyc(xoff);
        en = 1'b0;                          // R8 disable mid Tb
        push_off(xoff + 1, "R8 disable");
        push_off(xoff + 2, "R8 disable");

        wait_cyc(xoff + 2);
        apply(fd);
        en = 1'b1;
        base2 = xoff + 3;
        push_frame(base2, fd, "R9 R5 R6 R7 restart frame D");
        push_frame(base2 + FR, fd, "R1 repeat frame D");

        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule